// File: doc/BRIEF.md
# Local Memory Bus Slave with Wait States

This block is a slave on a simple single-master local memory bus, the kind a processor data port uses to reach tightly coupled storage. It holds a small array of 32-bit words and answers each transfer with two handshake outputs. `wait_o` tells the master that the transfer is accepted but not finished. `ready_o` marks the cycle in which the transfer completes. With zero configured wait states, reads and full-word writes complete in the strobe cycle and `wait_o` never rises. With a non-zero setting, completion is delayed by that many cycles.

When error-correcting storage is enabled, each word carries seven check bits: six Hamming bits and an overall parity bit. A write that does not enable all four byte lanes cannot be encoded from the bus data alone. For such a write the slave reads the stored word, corrects it, merges the new lanes, writes the merged word back, and only then signals completion. It holds `wait_o` high for the whole sequence. Reads report a correctable flag and an uncorrectable flag in their completion cycle. The read data bus is zero whenever no completion is signalled, so the outputs of several slaves can be OR-combined.

The controller has five states. `ST_IDLE` accepts strobes. `ST_HOLD` counts the configured latency. `ST_MERGE` reads, corrects and merges a word for a sub-word store. `ST_COMMIT` writes the merged word. `ST_DONE` drives `ready_o`.

The transitions are as follows:
- `ST_IDLE` to `ST_IDLE` on a zero-latency plain transfer.
- `ST_IDLE` to `ST_HOLD` when the latency is two or more.
- `ST_IDLE` to `ST_MERGE` for a sub-word store when the latency is 0 or 1.
- `ST_IDLE` to `ST_DONE` for a plain transfer when the latency is 1.
- `ST_HOLD` to `ST_HOLD` while the counter is non-zero.
- `ST_HOLD` to `ST_MERGE` or `ST_DONE` when the counter reaches zero.
- `ST_MERGE` to `ST_COMMIT`.
- `ST_COMMIT` to `ST_DONE`.
- `ST_DONE` to `ST_IDLE`.

Top module: `lmem_wait_slave`

## Requirements
- R1: With WAIT_STATES = 0, a read or a write with byte enables 4'b1111 drives `ready_o` in the strobe cycle, and `wait_o` stays low.
- R2: With WAIT_STATES = L > 0, a plain transfer drives `ready_o` in cycle L after the strobe cycle (cycle 0). `wait_o` is high in cycles 1 to L-1 and stays high until `ready_o` pulses.
- R3: `wait_o` and `ready_o` are never high in the same cycle. With L > 0, `ready_o` is a one-cycle pulse.
- R4: In the completion cycle of a read, `rdata_o` equals the word last written at `addr_i`.
- R5: Byte enable bit k selects lane k, bits 8k+7 to 8k, for update. Lanes that are not enabled keep their stored value.
- R6: With ECC_EN = 1, a write whose byte enables are not 4'b1111 completes in cycle max(L,1)+2, and `wait_o` is high in every cycle from 1 up to that cycle.
- R7: With ECC_EN = 1, a write with byte enables 4'b1111 skips the merge and completes in cycle L.
- R8: `rdata_o` is zero in every cycle in which `ready_o` is low, and also in write completions.
- R9: A strobe that arrives while a transfer is pending has no effect on storage or timing.
- R10: `ce_o` and `ue_o` are high only in a read completion cycle. Both stay low when the stored word is intact, and always when ECC_EN = 0.
- R11: A synchronous active-high `rst_i` abandons any pending transfer, drives `wait_o` and `ready_o` low in the next cycle, and clears every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Address strobe: starts a transfer when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | IDX_W | Word address |
| be_i | input | 4 | Byte-lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero unless a read completes |
| wait_o | output | 1 | Transfer accepted, not yet complete |
| ready_o | output | 1 | Transfer completes this cycle |
| ce_o | output | 1 | Correctable error on the completing read |
| ue_o | output | 1 | Uncorrectable error on the completing read |

## Verification
Each result falls due at a fixed cycle count from the strobe:
- Cycle L for reads and full-word writes.
- Cycle max(L,1)+2 for sub-word stores to protected storage.
- The cycle after a reset edge for the cleared handshake.

Two instances run side by side, one with L = 2 and one with L = 0. For each transfer, the bench counts cycles from the strobe and samples one nanosecond after each falling edge. It compares the index of the first `ready_o` cycle, the number of `wait_o` cycles and the completing data against values it computes from L and the byte enables. Write effects are checked by a later read, never in the completion cycle itself.

// File: rtl/lmws_pkg.sv
package lmws_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int HAM_W  = 6;
    localparam int CHK_W  = HAM_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_MERGE,
        ST_COMMIT,
        ST_DONE
    } lmws_state_e;

    // Codeword position of data bit idx: positions that are not powers of two
    function automatic int ham_pos(input int idx);
        int n;
        int res;
        n   = 0;
        res = 0;
        for (int p = 3; p < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx && res == 0) res = p;
                n++;
            end
        end
        return res;
    endfunction

    function automatic logic [HAM_W-1:0] ham_bits(input logic [WORD_W-1:0] d);
        logic [HAM_W-1:0] c;
        int p;
        c = '0;
        for (int i = 0; i < WORD_W; i++) begin
            p = ham_pos(i);
            for (int k = 0; k < HAM_W; k++) begin
                if (p[k]) c[k] = c[k] ^ d[i];
            end
        end
        return c;
    endfunction

    function automatic logic [CHK_W-1:0] ecc_encode(input logic [WORD_W-1:0] d);
        logic [HAM_W-1:0] c;
        c = ham_bits(d);
        return {^{d, c}, c};
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                     input logic [WORD_W-1:0] new_w,
                                                     input logic [LANES-1:0]  be);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            r[8*k +: 8] = be[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/lmws_ecc.sv
module lmws_ecc
    import lmws_pkg::*;
#(
    parameter int ECC_EN = 1
) (
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [CHK_W-1:0]  wr_chk_o,
    input  logic [WORD_W-1:0] rd_data_i,
    input  logic [CHK_W-1:0]  rd_chk_i,
    output logic [WORD_W-1:0] rd_fixed_o,
    output logic              rd_ce_o,
    output logic              rd_ue_o
);

    generate
        if (ECC_EN != 0) begin : gen_code
            logic [HAM_W-1:0] syn;
            logic             par;

            always_comb begin
                wr_chk_o = ecc_encode(wr_data_i);
                syn      = ham_bits(rd_data_i) ^ rd_chk_i[HAM_W-1:0];
                par      = ^{rd_data_i, rd_chk_i};
                rd_ce_o  = par;
                rd_ue_o  = !par && (syn != '0);
                for (int i = 0; i < WORD_W; i++) begin
                    rd_fixed_o[i] = rd_data_i[i] ^ (par && (ham_pos(i) == int'(syn)));
                end
            end
        end else begin : gen_plain
            logic unused_chk;
            assign unused_chk = ^rd_chk_i;
            assign wr_chk_o   = '0;
            assign rd_fixed_o = rd_data_i;
            assign rd_ce_o    = 1'b0;
            assign rd_ue_o    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/lmws_array.sv
module lmws_array
    import lmws_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic                    we_i,
    input  logic [WORD_W+CHK_W-1:0] wr_word_i,
    output logic [WORD_W+CHK_W-1:0] rd_word_o
);

    localparam int DEPTH  = 1 << IDX_W;
    localparam int CELL_W = WORD_W + CHK_W;

    logic [CELL_W-1:0] cells [DEPTH];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we_i) begin
            cells[idx_i] <= wr_word_i;
        end
    end

    assign rd_word_o = cells[idx_i];

endmodule

// File: rtl/lmws_fsm.sv
module lmws_fsm
    import lmws_pkg::*;
#(
    parameter int WAIT_STATES = 2,
    parameter int ECC_EN      = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             strobe_i,
    input  logic             we_i,
    input  logic [LANES-1:0] be_i,
    output lmws_state_e      state_o,
    output logic             cap_en_o,
    output logic             fire_now_o,
    output logic             wait_o,
    output logic             ready_o,
    output logic             wr_q_o,
    output logic             rmw_q_o
);

    localparam int CNT_W = (WAIT_STATES > 2) ? $clog2(WAIT_STATES - 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD =
        (WAIT_STATES >= 2) ? CNT_W'(WAIT_STATES - 2) : '0;

    lmws_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wr_q, rmw_q;
    logic             need_rmw;

    assign need_rmw = (ECC_EN != 0) && we_i && (be_i != {LANES{1'b1}});

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            wr_q  <= 1'b0;
            rmw_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == ST_IDLE && strobe_i) begin
                wr_q  <= we_i;
                rmw_q <= need_rmw;
            end
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (strobe_i) begin
                    if (WAIT_STATES >= 2) begin
                        st_d  = ST_HOLD;
                        cnt_d = CNT_LOAD;
                    end else if (need_rmw) begin
                        st_d = ST_MERGE;
                    end else if (WAIT_STATES == 1) begin
                        st_d = ST_DONE;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) st_d = rmw_q ? ST_MERGE : ST_DONE;
                else             cnt_d = cnt_q - 1'b1;
            end
            ST_MERGE:  st_d = ST_COMMIT;
            ST_COMMIT: st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_en_o   = (st_q == ST_IDLE) && strobe_i;
        fire_now_o = (WAIT_STATES == 0) && (st_q == ST_IDLE) && strobe_i && !need_rmw;
        wait_o     = (st_q == ST_HOLD) || (st_q == ST_MERGE) || (st_q == ST_COMMIT);
        ready_o    = fire_now_o || (st_q == ST_DONE);
        state_o    = st_q;
        wr_q_o     = wr_q;
        rmw_q_o    = rmw_q;
    end

endmodule

// File: rtl/lmem_wait_slave.sv
module lmem_wait_slave
    import lmws_pkg::*;
#(
    parameter int WAIT_STATES = 2,
    parameter int ECC_EN      = 1,
    parameter int IDX_W       = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              strobe_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              wait_o,
    output logic              ready_o,
    output logic              ce_o,
    output logic              ue_o
);

    lmws_state_e       st;
    logic              cap_en, fire_now, wr_q, rmw_q, idle;
    logic [IDX_W-1:0]  addr_q, idx;
    logic [LANES-1:0]  be_q, cur_be;
    logic [WORD_W-1:0] wdata_q, merged_q, cur_wdata;
    logic              cur_wr;
    logic [WORD_W+CHK_W-1:0] rd_word, wr_word;
    logic [WORD_W-1:0] fixed, arr_wdata;
    logic [CHK_W-1:0]  wr_chk;
    logic              rd_ce, rd_ue, arr_we;

    lmws_fsm #(.WAIT_STATES(WAIT_STATES), .ECC_EN(ECC_EN)) u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .strobe_i   (strobe_i),
        .we_i       (we_i),
        .be_i       (be_i),
        .state_o    (st),
        .cap_en_o   (cap_en),
        .fire_now_o (fire_now),
        .wait_o     (wait_o),
        .ready_o    (ready_o),
        .wr_q_o     (wr_q),
        .rmw_q_o    (rmw_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            addr_q   <= '0;
            be_q     <= '0;
            wdata_q  <= '0;
            merged_q <= '0;
        end else begin
            if (cap_en) begin
                addr_q  <= addr_i;
                be_q    <= be_i;
                wdata_q <= wdata_i;
            end
            if (st == ST_MERGE) merged_q <= lane_merge(fixed, wdata_q, be_q);
        end
    end

    assign idle      = (st == ST_IDLE);
    assign idx       = idle ? addr_i  : addr_q;
    assign cur_be    = idle ? be_i    : be_q;
    assign cur_wdata = idle ? wdata_i : wdata_q;
    assign cur_wr    = idle ? we_i    : wr_q;

    assign arr_wdata = (st == ST_COMMIT) ? merged_q : lane_merge(fixed, cur_wdata, cur_be);
    assign arr_we    = (fire_now && we_i)
                     || ((st == ST_DONE) && wr_q && !rmw_q)
                     || (st == ST_COMMIT);
    assign wr_word   = {wr_chk, arr_wdata};

    lmws_array #(.IDX_W(IDX_W)) u_array (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .idx_i     (idx),
        .we_i      (arr_we),
        .wr_word_i (wr_word),
        .rd_word_o (rd_word)
    );

    lmws_ecc #(.ECC_EN(ECC_EN)) u_ecc (
        .wr_data_i  (arr_wdata),
        .wr_chk_o   (wr_chk),
        .rd_data_i  (rd_word[WORD_W-1:0]),
        .rd_chk_i   (rd_word[WORD_W +: CHK_W]),
        .rd_fixed_o (fixed),
        .rd_ce_o    (rd_ce),
        .rd_ue_o    (rd_ue)
    );

    always_comb begin
        rdata_o = (ready_o && !cur_wr) ? fixed : '0;
        ce_o    = ready_o && !cur_wr && rd_ce;
        ue_o    = ready_o && !cur_wr && rd_ue;
    end

endmodule

// File: rtl/lmem_wait_slave_chk.sv
module lmem_wait_slave_chk #(
    parameter int WAIT_STATES = 2,
    parameter int ECC_EN      = 1
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic        strobe_i,
    input logic [31:0] rdata_o,
    input logic        wait_o,
    input logic        ready_o,
    input logic        ce_o,
    input logic        ue_o
);

    // R3
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wait_o && ready_o));

    // R3
    ready_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (WAIT_STATES > 0 && ready_o) |=> !ready_o);

    // R8
    rdata_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ready_o |-> rdata_o == '0);

    // R2
    wait_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wait_o |=> (wait_o || ready_o));

    // R2
    wait_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wait_o) |-> $past(strobe_i));

    // R10
    flag_time_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_o || ue_o) |-> ready_o);

    // R10
    flag_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ECC_EN == 0) |-> !(ce_o || ue_o));

endmodule

bind lmem_wait_slave lmem_wait_slave_chk #(
    .WAIT_STATES (WAIT_STATES),
    .ECC_EN      (ECC_EN)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (strobe_i),
    .rdata_o  (rdata_o),
    .wait_o   (wait_o),
    .ready_o  (ready_o),
    .ce_o     (ce_o),
    .ue_o     (ue_o)
);

// File: tb/sim_lmem_wait_slave.sv
`timescale 1ns/1ps
module sim_lmem_wait_slave;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as0 = 1'b0, as1 = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [3:0]  be = 4'hF;
    logic [31:0] wd = '0;
    logic [31:0] rd0, rd1;
    logic        wt0, wt1, rdy0, rdy1, ce0, ce1, ue0, ue1;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] model [2][16];

    always #2 clk = ~clk;

    lmem_wait_slave #(.WAIT_STATES(2), .ECC_EN(1), .IDX_W(4)) u0 (
        .clk_i(clk), .rst_i(rst), .strobe_i(as0), .we_i(we), .addr_i(addr),
        .be_i(be), .wdata_i(wd), .rdata_o(rd0), .wait_o(wt0), .ready_o(rdy0),
        .ce_o(ce0), .ue_o(ue0));

    lmem_wait_slave #(.WAIT_STATES(0), .ECC_EN(1), .IDX_W(4)) u1 (
        .clk_i(clk), .rst_i(rst), .strobe_i(as1), .we_i(we), .addr_i(addr),
        .be_i(be), .wdata_i(wd), .rdata_o(rd1), .wait_o(wt1), .ready_o(rdy1),
        .ce_o(ce1), .ue_o(ue1));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] b);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = b[k] ? n[8*k +: 8] : o[8*k +: 8];
        return r;
    endfunction

    function automatic int exp_lat(input int sel, input bit w, input logic [3:0] b);
        int l;
        l = (sel == 0) ? 2 : 0;
        if (w && b != 4'hF) return ((l > 1) ? l : 1) + 2;
        return l;
    endfunction

    // One transfer; counts cycles from the strobe cycle (0) to ready
    task automatic xfer(input int sel, input bit w, input logic [3:0] a,
                        input logic [3:0] b, input logic [31:0] d, input bit intrude,
                        output int lat, output int waits, output logic [31:0] rdv,
                        output bit flags, output bit quiet);
        logic [31:0] r;
        logic        wt, rdy, fl;
        lat = -1; waits = 0; rdv = '0; flags = 1'b0; quiet = 1'b1;
        @(negedge clk);
        we = w; addr = a; be = b; wd = d;
        if (sel == 0) as0 = 1'b1; else as1 = 1'b1;
        for (int c = 0; c < 20 && lat < 0; c++) begin
            if (c > 0) @(negedge clk);
            if (c == 1) begin
                if (intrude) begin
                    as0 = 1'b1; we = 1'b1; addr = a + 4'd1; be = 4'hF; wd = ~d;
                end else begin
                    as0 = 1'b0; as1 = 1'b0;
                end
            end
            if (c == 2) begin as0 = 1'b0; as1 = 1'b0; end
            #1;
            r   = (sel == 0) ? rd0 : rd1;
            wt  = (sel == 0) ? wt0 : wt1;
            rdy = (sel == 0) ? rdy0 : rdy1;
            fl  = (sel == 0) ? (ce0 | ue0) : (ce1 | ue1);
            if (rdy) begin
                lat = c; rdv = r; flags = fl;
                if (wt) quiet = 1'b0;
                if (w && r != 0) quiet = 1'b0;
            end else begin
                if (wt) waits++;
                if (r != 0 || fl) quiet = 1'b0;
            end
        end
        @(negedge clk);
        as0 = 1'b0; as1 = 1'b0;
    endtask

    task automatic do_write(input int sel, input logic [3:0] a, input logic [3:0] b,
                            input logic [31:0] d, input bit intrude, input string req);
        int lat, waits, el;
        logic [31:0] rv;
        bit fl, q;
        xfer(sel, 1'b1, a, b, d, intrude, lat, waits, rv, fl, q);
        el = exp_lat(sel, 1'b1, b);
        check(lat == el, req, "write latency", lat, el);
        check(waits == ((el > 0) ? el - 1 : 0), req, "write wait cycles", waits,
              (el > 0) ? el - 1 : 0);
        check(q, "R8", "rdata zero outside read completion", rv, 0);
        model[sel][a] = merge(model[sel][a], d, b);
    endtask

    task automatic do_read(input int sel, input logic [3:0] a, input string req);
        int lat, waits, el;
        logic [31:0] rv;
        bit fl, q;
        xfer(sel, 1'b0, a, 4'hF, 32'hDEAD_BEEF, 1'b0, lat, waits, rv, fl, q);
        el = exp_lat(sel, 1'b0, 4'hF);
        check(lat == el, (sel == 0) ? "R2" : "R1", "read latency", lat, el);
        check(waits == ((el > 0) ? el - 1 : 0), (sel == 0) ? "R2" : "R1",
              "read wait cycles", waits, (el > 0) ? el - 1 : 0);
        check(rv == model[sel][a], req, "read data", rv, model[sel][a]);
        check(!fl, "R10", "error flags on clean read", fl, 0);
        check(q, "R8", "rdata zero while not ready", 1, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) for (int a = 0; a < 16; a++) model[s][a] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!wt0 && !rdy0 && !wt1 && !rdy1, "R11", "handshake idle after reset",
              {wt0, rdy0, wt1, rdy1}, 0);

        for (int s = 0; s < 2; s++) begin
            // R11: storage is zero after reset
            for (int a = 0; a < 16; a++) do_read(s, 4'(a), "R11");
            // R7 / R1: full-word writes sweep all addresses
            for (int a = 0; a < 16; a++)
                do_write(s, 4'(a), 4'hF, 32'hA500_0000 ^ (32'(a) * 32'h0103_0507) ^ 32'(s),
                         1'b0, (s == 0) ? "R7" : "R1");
            for (int a = 0; a < 16; a++) do_read(s, 4'(a), "R4");
            // R6 / R5: every byte-enable pattern
            for (int b = 0; b < 16; b++) begin
                do_write(s, 4'(b), 4'(b), 32'hC3C3_C3C3 ^ (32'(b) * 32'h1111_1111),
                         1'b0, (b == 15) ? "R7" : "R6");
                do_read(s, 4'(b), "R5");
            end
        end

        // R9: strobe during a pending write on the L=2 instance is ignored
        do_write(0, 4'd6, 4'hF, 32'h1357_9BDF, 1'b1, "R9");
        do_read(0, 4'd7, "R9");
        do_read(0, 4'd6, "R9");
        do_write(0, 4'd9, 4'h3, 32'h2468_ACE0, 1'b1, "R9");
        do_read(0, 4'd10, "R9");
        do_read(0, 4'd9, "R9");

        // R11: reset in the middle of a pending transfer
        @(negedge clk);
        we = 1'b0; addr = 4'd3; as0 = 1'b1;
        @(negedge clk);
        as0 = 1'b0;
        #1;
        check(wt0 == 1'b1, "R2", "wait high in cycle 1", wt0, 1);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(!wt0 && !rdy0, "R11", "handshake cleared by reset", {wt0, rdy0}, 0);
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 2; s++) for (int a = 0; a < 16; a++) model[s][a] = '0;
        do_read(0, 4'd3, "R11");
        do_read(1, 4'd5, "R11");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule